// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Status

This block is the receive half of an asynchronous serial port. It watches the incoming line, using a tick that runs at sixteen times the bit rate. It finds each start bit and shifts in 5 to 8 data bits, least significant bit first. It then checks an optional parity bit and one stop bit. Each finished character goes into a single holding slot as a 12-bit entry: the data byte and four error flags. The entry stays there until software reads it.

A separate 4-bit status register gives the error state of the character most recently read. Its break, frame and parity bits change only when a read takes an entry out of the slot. Its overrun bit is set in the same clock as the overrun. Any write to the status register clears all four bits. The enables only decide whether a new start bit is accepted. A character that has already begun is always completed.

Top module: `serial_rx_errstat`

## Requirements
- R1: After reset, `rx_valid` is 0, `rx_entry` is 0 and `rx_status` is 0.
- R2: A received character is presented as `rx_entry` with the data in bits 7:0, the framing error in bit 8, the parity error in bit 9, the break error in bit 10 and the overrun error in bit 11. `rx_valid` is 1 and both stay unchanged until `rd_strobe` is pulsed, which clears `rx_valid`.
- R3: `wlen` selects the data width: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected width read as 0.
- R4: When `par_en` is 1, a parity bit follows the data. With `par_stick` at 0, `par_even` at 1 expects an even count of ones across data and parity, and `par_even` at 0 expects an odd count. With `par_stick` at 1, the parity bit is expected to be 0 if `par_even` is 1 and 1 if `par_even` is 0. A mismatch sets entry bit 9.
- R5: A low level sampled at the first stop position sets entry bit 8, and the data is kept.
- R6: A line that stays low from the start bit through the stop position gives a break entry: bits 10 and 8 set, bit 9 clear, data 0x00. After a break or a framing error, a new start is accepted only once the line has gone high again.
- R7: A low pulse that is high again at the mid-start check, 8 ticks after detection, is ignored, and no entry is produced.
- R8: Status bits 0 (frame), 1 (parity) and 2 (break) are loaded from the entry's bits 8, 9 and 10 when `rd_strobe` reads a valid entry, and at no other time. A completed character does not change them.
- R9: A character that completes while the slot still holds an unread entry is discarded. The held entry's bit 11 is set and status bit 3 is set in the same clock. Status bit 3 stays set until a status write.
- R10: A pulse on `st_wr` clears all four status bits. If a read happens in the same cycle, the clear takes priority.
- R11: Only the first stop bit is checked. A character followed directly by the next start bit after one stop bit is received correctly.
- R12: Clearing `rx_en` or `uart_en` during a character still completes that character. While either is 0, new start bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| wlen | input | 2 | Data width select (00 = 5 bits .. 11 = 8 bits) |
| par_en | input | 1 | Parity bit present and checked |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Fixed-value parity select |
| uart_en | input | 1 | Port enable |
| rx_en | input | 1 | Receive enable |
| rd_strobe | input | 1 | Read of the data word (takes the held entry) |
| st_wr | input | 1 | Write to the status register (clears it) |
| rx_entry | output | 12 | Held character entry with error flags |
| rx_valid | output | 1 | Holding slot contains an unread entry |
| rx_status | output | 4 | Status: frame, parity, break, overrun in bits 0..3 |

## Verification
The line passes through two synchronizer flops, and each sample is taken on a tick. A character's entry is therefore due a few clocks after the middle of its stop bit. The bench drives every bit for a full sixteen ticks and checks the entry only after the whole stop bit has been sent, so the entry is always settled when it is checked. Status changes caused by a read or a write are due one clock after the strobe and are sampled at the next falling edge. The overrun bit is checked right after the second unread character ends, before any read takes place.

// File: rtl/serial_rx_errstat.sv
module serial_rx_errstat #(
  parameter int OSR = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rxd,
  input  logic        tick16,
  input  logic [1:0]  wlen,
  input  logic        par_en,
  input  logic        par_even,
  input  logic        par_stick,
  input  logic        uart_en,
  input  logic        rx_en,
  input  logic        rd_strobe,
  input  logic        st_wr,
  output logic [11:0] rx_entry,
  output logic        rx_valid,
  output logic [3:0]  rx_status
);

  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_WAITHI} rx_state_t;

  rx_state_t      st;
  logic [1:0]     sync;
  logic           rx_s;
  logic [CW-1:0]  cnt;
  logic [2:0]     idx;
  logic [7:0]     shreg;
  logic           pbit;
  logic           all_low;

  assign rx_s = sync[1];

  wire        go       = uart_en && rx_en;
  wire [2:0]  last_idx = {1'b0, wlen} + 3'd4;
  wire        done     = tick16 && (st == S_STOP) && (cnt == LAST);
  wire        exp_par  = par_stick ? ~par_even : (par_even ? ^shreg : ~^shreg);
  wire        brk      = all_low && !rx_s;
  wire        fe       = !rx_s;
  wire        pe       = par_en && !brk && (pbit != exp_par);
  wire [10:0] new_ent  = {brk, pe, fe, brk ? 8'h00 : shreg};
  wire        rd_ok    = rd_strobe && rx_valid;
  wire        ovr      = done && rx_valid && !rd_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      pbit    <= 1'b0;
      all_low <= 1'b0;
    end else if (st == S_WAITHI) begin
      if (rx_s) st <= S_IDLE;
    end else if (tick16) begin
      case (st)
        S_IDLE: if (go && !rx_s) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: if (cnt == MID) begin
          cnt <= '0;
          if (rx_s) st <= S_IDLE;
          else begin
            st      <= S_DATA;
            idx     <= '0;
            shreg   <= '0;
            all_low <= 1'b1;
          end
        end else cnt <= cnt + 1'b1;
        S_DATA: if (cnt == LAST) begin
          cnt        <= '0;
          shreg[idx] <= rx_s;
          if (rx_s) all_low <= 1'b0;
          if (idx == last_idx) st <= par_en ? S_PAR : S_STOP;
          else idx <= idx + 1'b1;
        end else cnt <= cnt + 1'b1;
        S_PAR: if (cnt == LAST) begin
          cnt  <= '0;
          pbit <= rx_s;
          if (rx_s) all_low <= 1'b0;
          st   <= S_STOP;
        end else cnt <= cnt + 1'b1;
        S_STOP: if (cnt == LAST) begin
          cnt <= '0;
          st  <= rx_s ? S_IDLE : S_WAITHI;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_entry <= '0;
      rx_valid <= 1'b0;
    end else if (done) begin
      if (ovr) rx_entry[11] <= 1'b1;
      else begin
        rx_entry <= {1'b0, new_ent};
        rx_valid <= 1'b1;
      end
    end else if (rd_ok) begin
      rx_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_status <= '0;
    else if (st_wr) rx_status <= '0;
    else begin
      if (rd_ok) rx_status[2:0] <= rx_entry[10:8];
      if (ovr || (rd_ok && rx_entry[11])) rx_status[3] <= 1'b1;
    end
  end

  // R2: an unread entry is held unchanged
  a_r2_entry_held: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rd_strobe |=> rx_valid && $stable(rx_entry[10:0]));

  // R6: break entries carry the frame flag and zero data
  a_r6_break_form: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_entry[10] |-> rx_entry[8] && !rx_entry[9] && rx_entry[7:0] == 8'h00);

  // R8: a read copies the entry's error flags into status
  a_r8_read_loads: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && rx_valid && !st_wr |=> rx_status[2:0] == $past(rx_entry[10:8]));

  // R8: without read or write, the low status bits do not move
  a_r8_low_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe && !st_wr |=> $stable(rx_status[2:0]));

  // R9: the overrun status bit is sticky
  a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_status[3] && !st_wr |=> rx_status[3]);

  // R10: a status write clears every bit
  a_r10_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> rx_status == 4'b0000);

endmodule

// File: tb/tb_serial_rx_errstat.sv
module tb_serial_rx_errstat;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rxd = 1'b1;
  logic tick16 = 1'b0;
  logic [1:0] wlen = 2'b11;
  logic par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic uart_en = 1'b1, rx_en = 1'b1;
  logic rd_strobe = 1'b0, st_wr = 1'b0;
  logic [11:0] rx_entry;
  logic rx_valid;
  logic [3:0] rx_status;

  int checks = 0;
  int errors = 0;
  localparam int BITCYC = 32;

  always #2 clk = ~clk;

  serial_rx_errstat dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .tick16(tick16), .wlen(wlen),
    .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .uart_en(uart_en), .rx_en(rx_en), .rd_strobe(rd_strobe), .st_wr(st_wr),
    .rx_entry(rx_entry), .rx_valid(rx_valid), .rx_status(rx_status)
  );

  initial forever begin
    @(negedge clk);
    tick16 = ~tick16;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rxd = b;
    repeat (BITCYC) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit flip_par, input logic stopv,
                      input int drop_at);
    int nb;
    logic p;
    nb = int'(wlen) + 5;
    drive_bit(1'b0);
    for (int i = 0; i < nb; i++) begin
      if (i == drop_at) rx_en = 1'b0;
      drive_bit(d[i]);
    end
    if (par_en) begin
      p = 1'b0;
      for (int i = 0; i < nb; i++) p ^= d[i];
      p = par_stick ? ~par_even : (par_even ? p : ~p);
      drive_bit(p ^ flip_par);
    end
    drive_bit(stopv);
  endtask

  task automatic idle(input int bits);
    rxd = 1'b1;
    repeat (bits * BITCYC) @(negedge clk);
  endtask

  task automatic do_read;
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic do_write;
    st_wr = 1'b1;
    @(negedge clk);
    st_wr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid", rx_valid, 0);
    chk("R1 entry", rx_entry, 0);
    chk("R1 status", rx_status, 0);
  endtask

  task automatic t_basic;
    send(8'hA5, 0, 1'b1, -1); idle(1);
    chk("R2 valid", rx_valid, 1);
    chk("R2 entry", rx_entry, 12'h0A5);
    do_read;
    chk("R2 cleared", rx_valid, 0);
    send(8'h3C, 0, 1'b1, -1); idle(1);
    chk("R2 entry2", rx_entry, 12'h03C);
    do_read;
  endtask

  task automatic t_wlen;
    wlen = 2'b00; send(8'hFF, 0, 1'b1, -1); idle(1);
    chk("R3 five bits", rx_entry, 12'h01F); do_read;
    wlen = 2'b10; send(8'hD5, 0, 1'b1, -1); idle(1);
    chk("R3 seven bits", rx_entry, 12'h055); do_read;
    wlen = 2'b11;
  endtask

  task automatic t_parity;
    par_en = 1'b1; par_even = 1'b1;
    send(8'h07, 0, 1'b1, -1); idle(1);
    chk("R4 even good", rx_entry, 12'h007); do_read;
    send(8'h07, 1, 1'b1, -1); idle(1);
    chk("R4 even bad", rx_entry, 12'h207);
    chk("R8 status before read", rx_status, 0);
    do_read;
    chk("R8 status parity", rx_status, 4'h2);
    do_write;
    par_even = 1'b0;
    send(8'h07, 1, 1'b1, -1); idle(1);
    chk("R4 odd bad", rx_entry, 12'h207); do_read;
    par_stick = 1'b1; par_even = 1'b1;
    send(8'h81, 0, 1'b1, -1); idle(1);
    chk("R4 stick zero good", rx_entry, 12'h081); do_read;
    send(8'h81, 1, 1'b1, -1); idle(1);
    chk("R4 stick zero bad", rx_entry, 12'h281); do_read;
    par_en = 1'b0; par_stick = 1'b0; par_even = 1'b0;
    do_write;
  endtask

  task automatic t_frame;
    send(8'h5A, 0, 1'b0, -1); idle(2);
    chk("R5 frame entry", rx_entry, 12'h15A);
    do_read;
    chk("R8 status frame", rx_status, 4'h1);
    do_write;
    chk("R10 cleared", rx_status, 0);
  endtask

  task automatic t_break;
    rxd = 1'b0;
    repeat (14 * BITCYC) @(negedge clk);
    chk("R6 break entry", rx_entry, 12'h500);
    do_read;
    chk("R6 only one entry while low", rx_valid, 0);
    idle(2);
    chk("R6 no entry after release", rx_valid, 0);
    chk("R8 status break", rx_status, 4'h5);
    send(8'h42, 0, 1'b1, -1); idle(1);
    chk("R6 recovery", rx_entry, 12'h042);
    do_read; do_write;
  endtask

  task automatic t_glitch;
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    idle(2);
    chk("R7 glitch ignored", rx_valid, 0);
    send(8'h99, 0, 1'b1, -1); idle(1);
    chk("R7 next char", rx_entry, 12'h099);
    do_read;
  endtask

  task automatic t_overrun;
    send(8'h11, 0, 1'b1, -1); idle(1);
    send(8'h22, 0, 1'b1, -1); idle(1);
    chk("R9 held entry", rx_entry, 12'h811);
    chk("R9 status at once", rx_status, 4'h8);
    do_read;
    chk("R9 status after read", rx_status, 4'h8);
    do_write;
    chk("R10 overrun cleared", rx_status, 0);
  endtask

  task automatic t_write_wins;
    send(8'h66, 0, 1'b0, -1); idle(2);
    rd_strobe = 1'b1; st_wr = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0; st_wr = 1'b0;
    chk("R10 write wins", rx_status, 0);
    chk("R10 read still taken", rx_valid, 0);
  endtask

  task automatic t_one_stop;
    send(8'hC3, 0, 1'b1, -1);
    do_read;
    chk("R11 first", rx_status, 0);
    send(8'h3D, 0, 1'b1, -1); idle(1);
    chk("R11 second", rx_entry, 12'h03D);
    do_read;
  endtask

  task automatic t_disable;
    send(8'hB7, 0, 1'b1, 3); idle(1);
    chk("R12 completes", rx_entry, 12'h0B7);
    do_read;
    send(8'h12, 0, 1'b1, -1); idle(1);
    chk("R12 rx disabled ignored", rx_valid, 0);
    rx_en = 1'b1; uart_en = 1'b0;
    send(8'h34, 0, 1'b1, -1); idle(1);
    chk("R12 port disabled ignored", rx_valid, 0);
    uart_en = 1'b1;
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    idle(1);
    t_reset;
    t_basic;
    t_wlen;
    t_parity;
    t_frame;
    t_break;
    t_glitch;
    t_overrun;
    t_write_wins;
    t_one_stop;
    t_disable;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule